// File: doc/BRIEF.md
# I2C Target Interface with Byte-Level Clock Stretching

This block is the target (slave) end of a two-wire I2C bus. It watches an open-drain SCL/SDA pair, recognises START and STOP conditions and checks the first byte of each transfer against its own 7-bit address. It then moves data bytes in either direction, most significant bit first. It only ever pulls a line low or lets it go; a high level comes from the bus pull-ups.

After every byte of a transfer that addresses it, the block holds SCL low and raises a byte-complete event toward the core. The controller's clock stays stalled until the core answers. During that pause the core can drain the received byte, or supply the next byte to transmit. The receive side is a single holding register with a valid/ready handshake. If a new write byte completes while that register is still occupied, the byte is refused with a NACK and a buffer-full flag is raised.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset, both open-drain enables (sclOe, sdaOe) are low, and rxValid, byteEvt and bufFull are low.
- R2: The first byte after a START is an address byte. Bits 7..1 hold the 7-bit address and bit 0 is the direction (1 = read). When bits 7..1 equal OWN_ADDR, the block pulls SDA low through the ninth clock (ACK), and isRead takes the value of bit 0.
- R3: An address byte that does not match gets no ACK and raises no byte-complete event. The block then ignores the bus, including any later data bytes, until the next START.
- R4: In a write transfer, each data byte is captured MSB first. It is presented on rxData with rxValid high until the core asserts rxReady, and it is acknowledged with an ACK.
- R5: A write byte that completes while rxValid is still high is discarded and answered with a NACK, and the held byte stays unchanged. bufFull goes high and stays high until the next START or STOP.
- R6: At the SCL falling edge that ends the eighth bit of every byte of an addressed transfer, the block holds SCL low and raises byteEvt. Both stay high until the core pulses evtAck, and both drop in the cycle that follows.
- R7: In a read transfer, txData is taken at each evtAck. Starting at the falling edge of the acknowledge clock, that byte is shifted out MSB first.
- R8: When the controller answers a read byte with a NACK, the block releases SDA and stays idle until the next START.
- R9: A repeated START in the middle of a byte abandons the partial byte, and the next byte is decoded as an address.
- R10: The block changes sdaOe only while SCL is low, so its data never moves while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Level sensed on the SCL line |
| sclOe | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaIn | input | 1 | Level sensed on the SDA line |
| sdaOe | output | 1 | 1 pulls SDA low |
| rxData | output | DATA_W | Received write byte |
| rxValid | output | 1 | rxData holds an unread byte |
| rxReady | input | 1 | Core takes the byte on rxData |
| txData | input | DATA_W | Next byte to send, sampled at evtAck |
| byteEvt | output | 1 | Byte-complete event pending, SCL held low |
| evtAck | input | 1 | One-cycle pulse servicing byteEvt |
| isRead | output | 1 | Direction bit of the current transfer |
| bufFull | output | 1 | A write byte was refused since the last START or STOP |

## Verification
Each bus edge passes through a two-stage synchronizer and one edge register. The block's responses to it therefore appear after the third rising clock edge: the stretch and byteEvt after the eighth-bit fall, the ACK drive, the data shift and rxValid. The release of SCL comes one edge after evtAck. The bench's controller changes SDA only six cycles after it lowers SCL, and samples SDA at the end of a twelve-cycle high phase, so every value it reads has long settled. The core model waits 24 cycles after byteEvt and only then checks that SCL is still low, although the controller has released it by then. It then checks that sclOe has dropped at the first falling clock edge after its evtAck, and it compares received bytes from a queue at falling clock edges.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring the bus until START
    ST_RECV,   // shifting in address or write data
    ST_HOLD,   // SCL stretched, waiting on the core
    ST_ACK,    // ninth clock of a received byte
    ST_SEND,   // shifting out read data
    ST_PEEK    // ninth clock of a sent byte, listening to the controller
  } tgtState_e;

  typedef struct packed {
    logic capture;    // sample SDA into the shifter
    logic advance;    // move the next transmit bit to the MSB
    logic loadTx;     // load the shifter from txData
    logic pushRx;     // copy the shifter into the receive holding register
    logic clrCnt;     // restart the bit counter
    logic driveAck;   // pull SDA low for the acknowledge
    logic driveData;  // let the shifter MSB control SDA
    logic stretch;    // pull SCL low
  } tgtStb_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  tgtStb_t           stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxReady,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaNow,
  output logic              byteEnd,
  output logic [DATA_W-1:0] byteVal,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              sclOe,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLines, syncLines;
  logic             sclNow, sclQ, sdaQ;
  logic [CNT_W-1:0] bitCnt;
  logic [DATA_W-1:0] shReg;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawLines[g]),
      .dout (syncLines[g])
    );
  end

  assign sclNow = syncLines[1];
  assign sdaNow = syncLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclNow;
      sdaQ <= sdaNow;
    end
  end

  assign sclRise  = sclNow & ~sclQ;
  assign sclFall  = ~sclNow & sclQ;
  assign startDet = sclNow & sclQ & sdaQ & ~sdaNow;
  assign stopDet  = sclNow & sclQ & ~sdaQ & sdaNow;

  // bit counter: counts SCL rising edges, saturates at a full byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    bitCnt <= '0;
    else if (stb.clrCnt)                          bitCnt <= '0;
    else if (sclRise && bitCnt != CNT_W'(DATA_W)) bitCnt <= bitCnt + CNT_W'(1);
  end
  assign byteEnd = (bitCnt == CNT_W'(DATA_W));

  // shared shift register, MSB first in both directions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shReg <= '0;
    else if (stb.loadTx)  shReg <= txData;
    else if (stb.capture) shReg <= {shReg[DATA_W-2:0], sdaNow};
    else if (stb.advance) shReg <= {shReg[DATA_W-2:0], 1'b0};
  end
  assign byteVal = shReg;

  // single-entry receive holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
    end else if (stb.pushRx) begin
      rxData  <= shReg;
      rxValid <= 1'b1;
    end else if (rxReady) begin
      rxValid <= 1'b0;
    end
  end

  assign sdaOe = stb.driveAck | (stb.driveData & ~shReg[DATA_W-1]);
  assign sclOe = stb.stretch;

  // R10: SDA drive holds still across a high SCL
  p_sda_quiet_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sclNow && sclQ && !stopDet) |=> $stable(sdaOe));

  // R5: an unread byte is neither lost nor overwritten
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h42
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaNow,
  input  logic              byteEnd,
  input  logic [DATA_W-1:0] byteVal,
  input  logic              rxBusy,
  input  logic              evtAck,
  output tgtStb_t           stb,
  output logic              byteEvt,
  output logic              isRead,
  output logic              bufFull
);

  tgtState_e state, nxt;
  logic addrPhase, ackThis, holdTx, ctlNack, bufFullQ, isReadQ;
  logic addrHit;

  assign addrHit = (byteVal[DATA_W-1 -: ADDR_W] == OWN_ADDR);

  always_comb begin
    stb = '0;
    nxt = state;
    case (state)
      ST_IDLE: ;
      ST_RECV: begin
        stb.capture = sclRise;
        if (sclFall && byteEnd) begin
          if (addrPhase) begin
            nxt = addrHit ? ST_HOLD : ST_IDLE;
          end else begin
            nxt        = ST_HOLD;
            stb.pushRx = ~rxBusy;
          end
        end
      end
      ST_HOLD: begin
        stb.stretch  = 1'b1;
        stb.driveAck = ackThis & ~holdTx;
        if (evtAck) begin
          stb.loadTx = isReadQ;
          nxt        = holdTx ? ST_PEEK : ST_ACK;
        end
      end
      ST_ACK: begin
        stb.driveAck = ackThis;
        if (sclFall) begin
          stb.clrCnt = 1'b1;
          nxt = !ackThis ? ST_IDLE : (isReadQ ? ST_SEND : ST_RECV);
        end
      end
      ST_SEND: begin
        stb.driveData = 1'b1;
        if (sclFall) begin
          if (byteEnd) nxt = ST_HOLD;
          else         stb.advance = 1'b1;
        end
      end
      ST_PEEK: begin
        if (sclFall) begin
          stb.clrCnt = 1'b1;
          nxt = ctlNack ? ST_IDLE : ST_SEND;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (startDet) begin
      nxt        = ST_RECV;
      stb.clrCnt = 1'b1;
    end else if (stopDet) begin
      nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      addrPhase <= 1'b0;
      ackThis   <= 1'b0;
      holdTx    <= 1'b0;
      ctlNack   <= 1'b0;
      bufFullQ  <= 1'b0;
      isReadQ   <= 1'b0;
    end else begin
      state <= nxt;
      if (startDet) begin
        addrPhase <= 1'b1;
        holdTx    <= 1'b0;
        bufFullQ  <= 1'b0;
      end else if (stopDet) begin
        addrPhase <= 1'b0;
        bufFullQ  <= 1'b0;
      end else begin
        case (state)
          ST_RECV: if (sclFall && byteEnd) begin
            holdTx <= 1'b0;
            if (addrPhase) begin
              addrPhase <= 1'b0;
              isReadQ   <= byteVal[0];
              ackThis   <= 1'b1;
            end else begin
              ackThis <= ~rxBusy;
              if (rxBusy) bufFullQ <= 1'b1;
            end
          end
          ST_SEND: if (sclFall && byteEnd) holdTx <= 1'b1;
          ST_PEEK: if (sclRise) ctlNack <= sdaNow;
          default: ;
        endcase
      end
    end
  end

  assign byteEvt = (state == ST_HOLD);
  assign isRead  = isReadQ;
  assign bufFull = bufFullQ;

  // R6: SCL is let go only in answer to the core's service pulse
  p_release_on_service_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.stretch) |-> $past(evtAck));

  // R5: a refusal is flagged only while the holding register is occupied
  p_refuse_when_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |-> $past(rxBusy));

  // R3: a stretch never begins outside a byte boundary
  p_evt_at_byte_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteEvt) |-> $past(sclFall && byteEnd));

endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
  import i2c_tgt_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h42,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  output logic              sclOe,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [DATA_W-1:0] txData,
  output logic              byteEvt,
  input  logic              evtAck,
  output logic              isRead,
  output logic              bufFull
);

  tgtStb_t           stb;
  logic              sclRise, sclFall, startDet, stopDet, sdaNow, byteEnd;
  logic [DATA_W-1:0] byteVal;

  i2c_tgt_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .stb      (stb),
    .txData   (txData),
    .rxReady  (rxReady),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaNow   (sdaNow),
    .byteEnd  (byteEnd),
    .byteVal  (byteVal),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe)
  );

  i2c_tgt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OWN_ADDR(OWN_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaNow   (sdaNow),
    .byteEnd  (byteEnd),
    .byteVal  (byteVal),
    .rxBusy   (rxValid),
    .evtAck   (evtAck),
    .stb      (stb),
    .byteEvt  (byteEvt),
    .isRead   (isRead),
    .bufFull  (bufFull)
  );

endmodule

// File: tb/i2c_stretch_target_test.sv
module i2c_stretch_target_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;   // SCL high phase, in clocks
  localparam int QTR        = 6;    // settle time around SCL low, in clocks
  localparam int CORE_DLY   = 24;   // core reaction time to byteEvt
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic sclLine, sdaLine;
  logic sclOe, sdaOe;
  logic [7:0] rxData, txData = 8'h00;
  logic rxValid, rxReady = 1'b0;
  logic byteEvt, evtAck = 1'b0, isRead, bufFull;

  int nCmp = 0, nBad = 0;
  int evtCount = 0, violations = 0;
  bit rxTake = 1'b1;
  logic [7:0] expRx[$];
  logic [7:0] txQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sclLine = !(mSclLow || sclOe);
  assign sdaLine = !(mSdaLow || sdaOe);

  i2c_stretch_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sclOe(sclOe),
    .sdaIn(sdaLine), .sdaOe(sdaOe), .rxData(rxData), .rxValid(rxValid),
    .rxReady(rxReady), .txData(txData), .byteEvt(byteEvt), .evtAck(evtAck),
    .isRead(isRead), .bufFull(bufFull)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic releaseScl();
    mSclLow = 1'b0;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
  endtask

  // one SCL period, entered and left with SCL low
  task automatic bitOut(input bit b, output bit sampled);
    waitc(QTR);
    mSdaLow = !b;
    waitc(QTR);
    releaseScl();
    waitc(HALF);
    sampled = sdaLine;
    mSclLow = 1'b1;
  endtask

  task automatic doStart();
    mSdaLow = 1'b1;
    waitc(HALF);
    mSclLow = 1'b1;
  endtask

  task automatic doRestart();
    waitc(QTR);
    mSdaLow = 1'b0;
    waitc(QTR);
    releaseScl();
    waitc(HALF);
    mSdaLow = 1'b1;
    waitc(HALF);
    mSclLow = 1'b1;
  endtask

  task automatic doStop();
    waitc(QTR);
    mSdaLow = 1'b1;
    waitc(QTR);
    releaseScl();
    waitc(HALF);
    mSdaLow = 1'b0;
    waitc(HALF);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bitOut(d[i], s);
    bitOut(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bitOut(1'b1, s);
      d[i] = s;
    end
    bitOut(!ackIt, s);
  endtask

  // core model: services each byte-complete event after a delay
  initial begin
    forever begin
      @(negedge clk);
      if (byteEvt) begin
        waitc(CORE_DLY);
        // R6: line still held low by the target though the controller let go
        check(!sclLine && !mSclLow && byteEvt, "R6", "scl stretched",
              int'(sclLine), 0);
        if (isRead) txData = (txQ.size() > 0) ? txQ.pop_front() : 8'hFF;
        evtAck = 1'b1;
        @(negedge clk);
        evtAck = 1'b0;
        check(!sclOe && !byteEvt, "R6", "stretch released after evtAck",
              int'(sclOe), 0);
      end
    end
  end

  // scoreboard monitor for received bytes
  initial begin
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (rxValid && rxTake) begin
        if (expRx.size() == 0) begin
          check(1'b0, "R4", "unexpected rx byte", int'(rxData), 0);
        end else begin
          e = expRx.pop_front();
          check(rxData == e, "R4", "rx byte", int'(rxData), int'(e));
        end
        rxReady = 1'b1;
        @(negedge clk);
        rxReady = 1'b0;
      end
    end
  end

  // event counter and SDA-during-high monitor
  initial begin
    bit evtPrev = 1'b0, sclPrev = 1'b1, oePrev = 1'b0;
    forever begin
      @(negedge clk);
      if (byteEvt && !evtPrev) evtCount++;
      if (rstN && sclLine && sclPrev && (sdaOe != oePrev)) violations++;
      evtPrev = byteEvt;
      sclPrev = sclLine;
      oePrev  = sdaOe;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    logic [7:0] wr[3];
    int evBefore;

    wr[0] = 8'h5A; wr[1] = 8'hC3; wr[2] = 8'h01;

    waitc(4);
    // R1: reset state
    check(!sclOe && !sdaOe, "R1", "open-drain enables", int'({sclOe, sdaOe}), 0);
    check(!rxValid && !byteEvt && !bufFull, "R1", "status outputs",
          int'({rxValid, byteEvt, bufFull}), 0);
    rstN = 1'b1;
    waitc(6);

    // write transfer: address 0x42 + W, three data bytes
    evBefore = evtCount;
    doStart();
    sendByte(8'h84, ack);
    check(ack, "R2", "address ACK (write)", int'(ack), 1);
    check(!isRead, "R2", "direction write", int'(isRead), 0);
    foreach (wr[i]) begin
      expRx.push_back(wr[i]);
      sendByte(wr[i], ack);
      check(ack, "R4", "data ACK", int'(ack), 1);
    end
    doStop();
    waitc(20);
    check(expRx.size() == 0, "R4", "all written bytes delivered", expRx.size(), 0);
    check(evtCount - evBefore == 4, "R6", "one event per byte", evtCount - evBefore, 4);

    // mismatched address
    evBefore = evtCount;
    doStart();
    sendByte(8'h46, ack);
    check(!ack, "R3", "mismatched address NACK", int'(ack), 0);
    sendByte(8'h77, ack);
    check(!ack, "R3", "data ignored after mismatch", int'(ack), 0);
    doStop();
    waitc(10);
    check(evtCount == evBefore, "R3", "no event on mismatch", evtCount - evBefore, 0);
    check(!rxValid, "R3", "no byte delivered", int'(rxValid), 0);

    // read transfer: three bytes, last one NACKed
    txQ.push_back(8'hA5); txQ.push_back(8'h3C); txQ.push_back(8'h81);
    doStart();
    sendByte(8'h85, ack);
    check(ack, "R2", "address ACK (read)", int'(ack), 1);
    check(isRead, "R7", "direction read", int'(isRead), 1);
    recvByte(1'b1, d);
    check(d == 8'hA5, "R7", "read byte 0", int'(d), 8'hA5);
    recvByte(1'b1, d);
    check(d == 8'h3C, "R7", "read byte 1", int'(d), 8'h3C);
    recvByte(1'b0, d);
    check(d == 8'h81, "R7", "read byte 2", int'(d), 8'h81);
    waitc(6);
    check(!sdaOe, "R8", "SDA released after controller NACK", int'(sdaOe), 0);
    waitc(QTR);
    check(!sdaOe && !byteEvt, "R8", "target idle after NACK",
          int'({sdaOe, byteEvt}), 0);
    doStop();
    waitc(10);

    // buffer full: core does not drain the holding register
    rxTake = 1'b0;
    doStart();
    sendByte(8'h84, ack);
    check(ack, "R2", "address ACK", int'(ack), 1);
    expRx.push_back(8'h96);
    sendByte(8'h96, ack);
    check(ack, "R5", "first byte accepted", int'(ack), 1);
    sendByte(8'h69, ack);
    check(!ack, "R5", "second byte refused", int'(ack), 0);
    waitc(4);
    check(bufFull, "R5", "buffer-full flag", int'(bufFull), 1);
    check(rxValid && rxData == 8'h96, "R5", "held byte kept", int'(rxData), 8'h96);
    doStop();
    waitc(6);
    check(!bufFull, "R5", "flag cleared by STOP", int'(bufFull), 0);
    rxTake = 1'b1;
    waitc(10);
    check(expRx.size() == 0, "R5", "held byte drained", expRx.size(), 0);

    // repeated START in the middle of a data byte
    doStart();
    sendByte(8'h84, ack);
    begin
      bit s;
      bitOut(1'b1, s);
      bitOut(1'b0, s);
      bitOut(1'b1, s);
    end
    doRestart();
    sendByte(8'h84, ack);
    check(ack, "R9", "address decoded after repeated START", int'(ack), 1);
    expRx.push_back(8'h3E);
    sendByte(8'h3E, ack);
    check(ack, "R9", "data after repeated START", int'(ack), 1);
    doStop();
    waitc(10);
    check(expRx.size() == 0, "R9", "partial byte discarded", expRx.size(), 0);

    check(violations == 0, "R10", "sdaOe changes while SCL high", violations, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule